// File: doc/BRIEF.md
# Power domain switch sequencer

This block takes one switchable logic domain through its power-up and power-down sequences. A controller pulses a request together with a direction bit. The sequencer then drives a control word in a fixed order of steps. That word holds a two-stage power-switch enable, a clock disable, an isolation enable, an active-low domain reset and a group of SRAM power-down bits. Between steps it waits on feedback from outside the block: two power-acknowledge status lines, a masked SRAM power-down acknowledge word, and the acknowledge of a bus-protection request.

Every wait has a cycle-count limit. If a wait runs out during power-up, the block reports an error and steps the domain back to its off state. If a wait runs out during power-down, it reports an error and stops where it is. Parameters set which bits are SRAM power-down controls, which acknowledge bits count, and which bus-protection lines are used. A zero mask removes the matching handshake from both sequences.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the control word has bit 0 (active-low domain reset) = 0, bit 1 (isolation) = 1, bit 2 (first power stage) = 0, bit 3 (second power stage) = 0, bit 4 (clock disable) = 1, and every bit of the SRAM power-down mask = 1. The bus-protection request equals its mask, and busy, done and error are 0.
- R2: Power-up sets bit 2, then sets bit 3, then waits for both power status inputs to be 1. It then clears bit 4, clears bit 1, sets bit 0 and clears the SRAM power-down bits, in that order.
- R3: After clearing the SRAM power-down bits on power-up, the block waits until all masked SRAM acknowledge bits are 0. Only then does it drop the bus-protection request. It waits for all masked protection acknowledges to read 0, then reports done. While protection is released, the SRAM power-down bits are 0.
- R4: Power-down raises the bus-protection request and waits for all masked acknowledges to read 1. It then sets the SRAM power-down bits and waits for all masked SRAM acknowledges to read 1. Next it sets isolation, asserts reset, sets clock disable, clears bit 2 and clears bit 3, and finally waits for both power status inputs to be 0.
- R5: The domain counts as on only when both power status inputs are 1, and as off only when both are 0. When the two disagree, the block keeps waiting.
- R6: SRAM acknowledge bits outside the mask have no effect. A zero SRAM acknowledge mask skips the SRAM wait. A zero bus-protection mask skips the protection handshake and leaves the request at 0.
- R7: A wait that is still unmet after TIMEOUT_CYCLES cycles raises error for one cycle and never gives done. On power-up the block then restores the R1 control word and reasserts protection. On power-down it stops and leaves the control word as it was.
- R8: Busy is 1 from the cycle after an accepted request until the sequence ends. A request that arrives while busy is ignored, and the control word does not change while idle.
- R9: Done is a single-cycle pulse at the end of a completed sequence. It is never high together with error.
- R10: Each control step is held for at least one clock cycle before the next one, so no two of bits 0 to 4 change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a sequence (sampled when idle) |
| on_i | input | 1 | Direction: 1 power up, 0 power down |
| pwr_ack_a_i | input | 1 | First power status input |
| pwr_ack_b_i | input | 1 | Second power status input |
| sram_ack_i | input | ACK_W | SRAM power-down acknowledge word |
| bus_prot_ack_i | input | BP_W | Bus-protection acknowledge lines |
| ctl_o | output | CTL_W | Domain control word |
| bus_prot_req_o | output | BP_W | Bus-protection request lines |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse |

## Verification
The main instance is built with TIMEOUT_CYCLES = 16, SRAM power-down bits 8 to 11, acknowledge bits 12 to 15 and two protection lines. With so short a limit, stuck acknowledges in each wait and both abort paths can be reached in a few dozen cycles. The environment model sweeps its acknowledge delays from 0 to 3 cycles, and it skews the two power status lines to hold them in disagreement. A second instance has every mask at zero, with its SRAM and protection acknowledges tied to values that would stall a wait, so any skip that is missing shows up as a hang or a timeout.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int B_RSTN   = 0;
    localparam int B_ISO    = 1;
    localparam int B_PWR1   = 2;
    localparam int B_PWR2   = 3;
    localparam int B_CLKDIS = 4;

    typedef enum logic [4:0] {
        S_IDLE,
        S_UP_PWR1,
        S_UP_PWR2,
        S_UP_WPWR,
        S_UP_CLK,
        S_UP_ISO,
        S_UP_RST,
        S_UP_SRAM,
        S_UP_WSRAM,
        S_UP_BUS,
        S_UP_WBUS,
        S_DN_BUS,
        S_DN_WBUS,
        S_DN_SRAM,
        S_DN_WSRAM,
        S_DN_ISO,
        S_DN_RST,
        S_DN_CLK,
        S_DN_PWR1,
        S_DN_PWR2,
        S_DN_WPWR
    } seq_state_e;

    function automatic logic is_wait(seq_state_e s);
        return (s == S_UP_WPWR) || (s == S_UP_WSRAM) || (s == S_UP_WBUS) ||
               (s == S_DN_WBUS) || (s == S_DN_WSRAM) || (s == S_DN_WPWR);
    endfunction

endpackage

// File: rtl/pds_timeout.sv
module pds_timeout #(
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/pds_ack_eval.sv
module pds_ack_eval #(
    parameter int               ACK_W         = 32,
    parameter int               BP_W          = 4,
    parameter logic [ACK_W-1:0] SRAM_ACK_MASK = '0,
    parameter logic [BP_W-1:0]  BP_MASK       = '0
) (
    input  logic             pwr_a_i,
    input  logic             pwr_b_i,
    input  logic [ACK_W-1:0] sram_ack_i,
    input  logic [BP_W-1:0]  bus_ack_i,
    output logic             pwr_on_o,
    output logic             pwr_off_o,
    output logic             sram_set_o,
    output logic             sram_clr_o,
    output logic             bus_set_o,
    output logic             bus_clr_o
);
    logic [ACK_W-1:0] sram_m;
    logic [BP_W-1:0]  bus_m;

    for (genvar i = 0; i < ACK_W; i++) begin : g_sram
        assign sram_m[i] = sram_ack_i[i] & SRAM_ACK_MASK[i];
    end
    for (genvar j = 0; j < BP_W; j++) begin : g_bus
        assign bus_m[j] = bus_ack_i[j] & BP_MASK[j];
    end

    // both status lines must agree before the domain counts as on or off
    assign pwr_on_o   = pwr_a_i & pwr_b_i;
    assign pwr_off_o  = ~pwr_a_i & ~pwr_b_i;
    assign sram_set_o = (sram_m == SRAM_ACK_MASK);
    assign sram_clr_o = (sram_m == '0);
    assign bus_set_o  = (bus_m == BP_MASK);
    assign bus_clr_o  = (bus_m == '0);

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pds_pkg::*;
#(
    parameter int               CTL_W          = 32,
    parameter int               ACK_W          = 32,
    parameter int               BP_W           = 4,
    parameter logic [CTL_W-1:0] SRAM_PDN_MASK  = 32'h0000_0F00,
    parameter logic [ACK_W-1:0] SRAM_ACK_MASK  = 32'h0000_F000,
    parameter logic [BP_W-1:0]  BP_MASK        = 4'b0011,
    parameter int               TIMEOUT_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             on_i,
    input  logic             pwr_ack_a_i,
    input  logic             pwr_ack_b_i,
    input  logic [ACK_W-1:0] sram_ack_i,
    input  logic [BP_W-1:0]  bus_prot_ack_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [BP_W-1:0]  bus_prot_req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam logic [CTL_W-1:0] CTL_OFF   = SRAM_PDN_MASK | CTL_W'(5'b10010);
    localparam logic             SKIP_SRAM = (SRAM_ACK_MASK == '0);
    localparam logic             SKIP_BUS  = (BP_MASK == '0);
    localparam logic [CTL_W-1:0] STEP_BITS = CTL_W'(5'b11111);

    typedef struct packed {
        seq_state_e       st;
        logic [CTL_W-1:0] ctl;
        logic [BP_W-1:0]  bus_req;
        logic             abort;
        logic             done;
        logic             err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic pwr_on, pwr_off, sram_set, sram_clr, bus_set, bus_clr;
    logic tmo;

    pds_ack_eval #(
        .ACK_W         (ACK_W),
        .BP_W          (BP_W),
        .SRAM_ACK_MASK (SRAM_ACK_MASK),
        .BP_MASK       (BP_MASK)
    ) u_eval (
        .pwr_a_i    (pwr_ack_a_i),
        .pwr_b_i    (pwr_ack_b_i),
        .sram_ack_i (sram_ack_i),
        .bus_ack_i  (bus_prot_ack_i),
        .pwr_on_o   (pwr_on),
        .pwr_off_o  (pwr_off),
        .sram_set_o (sram_set),
        .sram_clr_o (sram_clr),
        .bus_set_o  (bus_set),
        .bus_clr_o  (bus_clr)
    );

    pds_timeout #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (is_wait(r_q.st)),
        .expired_o (tmo)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (req_i) begin
                    r_d.abort = 1'b0;
                    r_d.st    = on_i ? S_UP_PWR1 : S_DN_BUS;
                end
            end
            S_UP_PWR1: begin
                r_d.ctl[B_PWR1] = 1'b1;
                r_d.st          = S_UP_PWR2;
            end
            S_UP_PWR2: begin
                r_d.ctl[B_PWR2] = 1'b1;
                r_d.st          = S_UP_WPWR;
            end
            S_UP_WPWR: begin
                if (pwr_on) begin
                    r_d.st = S_UP_CLK;
                end else if (tmo) begin
                    r_d.err     = 1'b1;
                    r_d.abort   = 1'b1;
                    r_d.bus_req = BP_MASK;
                    r_d.st      = S_DN_SRAM;
                end
            end
            S_UP_CLK: begin
                r_d.ctl[B_CLKDIS] = 1'b0;
                r_d.st            = S_UP_ISO;
            end
            S_UP_ISO: begin
                r_d.ctl[B_ISO] = 1'b0;
                r_d.st         = S_UP_RST;
            end
            S_UP_RST: begin
                r_d.ctl[B_RSTN] = 1'b1;
                r_d.st          = S_UP_SRAM;
            end
            S_UP_SRAM: begin
                r_d.ctl = r_q.ctl & ~SRAM_PDN_MASK;
                r_d.st  = SKIP_SRAM ? S_UP_BUS : S_UP_WSRAM;
            end
            S_UP_WSRAM: begin
                if (sram_clr) begin
                    r_d.st = S_UP_BUS;
                end else if (tmo) begin
                    r_d.err     = 1'b1;
                    r_d.abort   = 1'b1;
                    r_d.bus_req = BP_MASK;
                    r_d.st      = S_DN_SRAM;
                end
            end
            S_UP_BUS: begin
                if (SKIP_BUS) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.bus_req = '0;
                    r_d.st      = S_UP_WBUS;
                end
            end
            S_UP_WBUS: begin
                if (bus_clr) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else if (tmo) begin
                    r_d.err     = 1'b1;
                    r_d.abort   = 1'b1;
                    r_d.bus_req = BP_MASK;
                    r_d.st      = S_DN_SRAM;
                end
            end
            S_DN_BUS: begin
                if (SKIP_BUS) begin
                    r_d.st = S_DN_SRAM;
                end else begin
                    r_d.bus_req = BP_MASK;
                    r_d.st      = S_DN_WBUS;
                end
            end
            S_DN_WBUS: begin
                if (bus_set) begin
                    r_d.st = S_DN_SRAM;
                end else if (tmo) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end
            end
            S_DN_SRAM: begin
                r_d.ctl = r_q.ctl | SRAM_PDN_MASK;
                r_d.st  = (SKIP_SRAM || r_q.abort) ? S_DN_ISO : S_DN_WSRAM;
            end
            S_DN_WSRAM: begin
                if (sram_set) begin
                    r_d.st = S_DN_ISO;
                end else if (tmo) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end
            end
            S_DN_ISO: begin
                r_d.ctl[B_ISO] = 1'b1;
                r_d.st         = S_DN_RST;
            end
            S_DN_RST: begin
                r_d.ctl[B_RSTN] = 1'b0;
                r_d.st          = S_DN_CLK;
            end
            S_DN_CLK: begin
                r_d.ctl[B_CLKDIS] = 1'b1;
                r_d.st            = S_DN_PWR1;
            end
            S_DN_PWR1: begin
                r_d.ctl[B_PWR1] = 1'b0;
                r_d.st          = S_DN_PWR2;
            end
            S_DN_PWR2: begin
                r_d.ctl[B_PWR2] = 1'b0;
                r_d.abort       = 1'b0;
                r_d.st          = r_q.abort ? S_IDLE : S_DN_WPWR;
            end
            S_DN_WPWR: begin
                if (pwr_off) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else if (tmo) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, ctl: CTL_OFF, bus_req: BP_MASK,
                     abort: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_o          = r_q.ctl;
    assign bus_prot_req_o = r_q.bus_req;
    assign busy_o         = (r_q.st != S_IDLE);
    assign done_o         = r_q.done;
    assign err_o          = r_q.err;

    // R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(r_q.st != S_IDLE));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && $past(r_q.st == S_IDLE)) |-> $stable(r_q.ctl));

    // R2
    iso_open_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[B_ISO] |-> (ctl_o[B_PWR1] && ctl_o[B_PWR2] && !ctl_o[B_CLKDIS]));

    // R2
    rst_rel_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[B_RSTN] |-> (ctl_o[B_PWR1] && ctl_o[B_PWR2]));

    // R3
    bus_open_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_prot_req_o != BP_MASK) |-> ((ctl_o & SRAM_PDN_MASK) == '0));

    // R10
    step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones((ctl_o ^ $past(ctl_o)) & STEP_BITS) <= 1);

endmodule

// File: tb/pwr_domain_seq_bench.sv
module pwr_domain_seq_bench;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    int wd = 0;

    // main instance
    logic        req = 1'b0, on = 1'b0;
    logic        pa, pb;
    logic [3:0]  sram_cur;
    logic [1:0]  bus_cur;
    logic [31:0] sram_ack;
    logic [31:0] ctl;
    logic [1:0]  bus_req;
    logic        busy, done, err;

    assign sram_ack = {16'hA5A5, sram_cur, 12'h0};

    pwr_domain_seq #(
        .CTL_W(32), .ACK_W(32), .BP_W(2),
        .SRAM_PDN_MASK(32'h0000_0F00), .SRAM_ACK_MASK(32'h0000_F000),
        .BP_MASK(2'b11), .TIMEOUT_CYCLES(TMO)
    ) u_pwr_domain_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .on_i(on),
        .pwr_ack_a_i(pa), .pwr_ack_b_i(pb), .sram_ack_i(sram_ack),
        .bus_prot_ack_i(bus_cur), .ctl_o(ctl), .bus_prot_req_o(bus_req),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    // instance with every mask zero
    logic        breq = 1'b0, bon = 1'b0;
    logic        bpa, bpb;
    logic [31:0] bctl;
    logic [1:0]  bbus_req;
    logic        bbusy, bdone, berr;

    pwr_domain_seq #(
        .CTL_W(32), .ACK_W(32), .BP_W(2),
        .SRAM_PDN_MASK(32'h0), .SRAM_ACK_MASK(32'h0),
        .BP_MASK(2'b00), .TIMEOUT_CYCLES(TMO)
    ) u_pwr_domain_seq_bare (
        .clk(clk), .rst_n(rst_n), .req_i(breq), .on_i(bon),
        .pwr_ack_a_i(bpa), .pwr_ack_b_i(bpb), .sram_ack_i(32'hFFFF_FFFF),
        .bus_prot_ack_i(2'b11), .ctl_o(bctl), .bus_prot_req_o(bbus_req),
        .busy_o(bbusy), .done_o(bdone), .err_o(berr)
    );

    // environment model: each ack follows its target after a delay, unless stuck
    int d_pa = 0, d_pb = 0, d_sram = 0, d_bus = 0;
    logic st_pa = 1'b0, st_pb = 1'b0, st_sram = 1'b0, st_bus = 1'b0;
    int c_pa, c_pb, c_sram, c_bus;

    always @(posedge clk) begin
        if (!rst_n) begin
            pa <= 1'b0; pb <= 1'b0; sram_cur <= 4'hF; bus_cur <= 2'b11;
            c_pa <= 0; c_pb <= 0; c_sram <= 0; c_bus <= 0;
            bpa <= 1'b0; bpb <= 1'b0;
        end else begin
            bpa <= bctl[2];
            bpb <= bctl[3];
            if (!st_pa && pa != ctl[2]) begin
                if (c_pa >= d_pa) begin pa <= ctl[2]; c_pa <= 0; end
                else c_pa <= c_pa + 1;
            end else c_pa <= 0;
            if (!st_pb && pb != ctl[3]) begin
                if (c_pb >= d_pb) begin pb <= ctl[3]; c_pb <= 0; end
                else c_pb <= c_pb + 1;
            end else c_pb <= 0;
            if (!st_sram && sram_cur != ctl[11:8]) begin
                if (c_sram >= d_sram) begin sram_cur <= ctl[11:8]; c_sram <= 0; end
                else c_sram <= c_sram + 1;
            end else c_sram <= 0;
            if (!st_bus && bus_cur != bus_req) begin
                if (c_bus >= d_bus) begin bus_cur <= bus_req; c_bus <= 0; end
                else c_bus <= c_bus + 1;
            end else c_bus <= 0;
        end
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < 100000", wd);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_run = n_run + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_order(input string tag, input string what, input int a, input int b);
        chk(a >= 0 && b > a, tag, what, b, a + 1);
    endtask

    int s_p1, s_p2, s_clk, s_iso, s_rst, s_sram, s_bus, s_pack, s_sack, s_back, s_done;
    int n_done, n_err, last_cyc;

    task automatic run_seq(input logic dir, input int inj);
        logic [31:0] pc;
        logic [1:0]  pbq;
        logic [31:0] diff;
        int cyc;
        pc = ctl; pbq = bus_req;
        s_p1 = -1; s_p2 = -1; s_clk = -1; s_iso = -1; s_rst = -1; s_sram = -1;
        s_bus = -1; s_pack = -1; s_sack = -1; s_back = -1; s_done = -1;
        n_done = 0; n_err = 0; cyc = 0;
        req = 1'b1; on = dir;
        @(negedge clk);
        while (cyc < 400) begin
            cyc++;
            if (inj > 0 && cyc == inj) begin req = 1'b1; on = ~dir; end
            else req = 1'b0;
            diff = ctl ^ pc;
            if (diff[2]) s_p1 = cyc;
            if (diff[3]) s_p2 = cyc;
            if (diff[4]) s_clk = cyc;
            if (diff[1]) s_iso = cyc;
            if (diff[0]) s_rst = cyc;
            if (|diff[11:8]) s_sram = cyc;
            if (bus_req != pbq) s_bus = cyc;
            if (s_pack < 0 && pa == dir && pb == dir) s_pack = cyc;
            if (s_sack < 0 && sram_cur == (dir ? 4'h0 : 4'hF)) s_sack = cyc;
            if (s_back < 0 && bus_cur == (dir ? 2'b00 : 2'b11)) s_back = cyc;
            if (done) begin n_done++; s_done = cyc; end
            if (err) n_err++;
            pc = ctl; pbq = bus_req;
            if (!busy) break;
            @(negedge clk);
        end
        req = 1'b0;
        last_cyc = cyc;
    endtask

    task automatic check_up();
        chk_order("R2", "pwr1 before pwr2", s_p1, s_p2);
        chk_order("R5", "both status on after pwr2", s_p2, s_pack);
        chk_order("R2", "clock enable after status on", s_pack, s_clk);
        chk_order("R10", "isolation after clock", s_clk, s_iso);
        chk_order("R10", "reset release after isolation", s_iso, s_rst);
        chk_order("R2", "sram on after reset release", s_rst, s_sram);
        chk_order("R3", "sram ack clear after sram on", s_sram, s_sack);
        chk_order("R3", "protection release after sram ack", s_sack, s_bus);
        chk_order("R3", "done after protection ack", s_back, s_done);
        chk(n_done == 1, "R9", "done pulses on power-up", n_done, 1);
        chk(n_err == 0, "R9", "no error on power-up", n_err, 0);
        chk(ctl == 32'h0000_000D, "R2", "control word when on", ctl, 32'h0000_000D);
        chk(bus_req == 2'b00, "R3", "protection released", bus_req, 0);
    endtask

    task automatic check_down();
        chk_order("R4", "protection ack after request", s_bus, s_back);
        chk_order("R4", "sram off after protection ack", s_back, s_sram);
        chk_order("R4", "sram ack set after sram off", s_sram, s_sack);
        chk_order("R4", "isolation after sram ack", s_sack, s_iso);
        chk_order("R10", "reset after isolation", s_iso, s_rst);
        chk_order("R10", "clock disable after reset", s_rst, s_clk);
        chk_order("R4", "pwr1 off after clock disable", s_clk, s_p1);
        chk_order("R4", "pwr2 off after pwr1", s_p1, s_p2);
        chk_order("R5", "done after both status off", s_pack, s_done);
        chk(n_done == 1, "R9", "done pulses on power-down", n_done, 1);
        chk(n_err == 0, "R9", "no error on power-down", n_err, 0);
        chk(ctl == 32'h0000_0F12, "R4", "control word when off", ctl, 32'h0000_0F12);
        chk(bus_req == 2'b11, "R4", "protection held", bus_req, 2'b11);
    endtask

    task automatic run_bare(input logic dir, input logic [31:0] exp_ctl);
        int cyc, nd;
        nd = 0; cyc = 0;
        breq = 1'b1; bon = dir;
        @(negedge clk);
        breq = 1'b0;
        while (cyc < 200) begin
            cyc++;
            if (bdone) nd++;
            if (!bbusy) break;
            @(negedge clk);
        end
        chk(nd == 1, "R6", "bare sequence completes with zero masks", nd, 1);
        chk(bctl == exp_ctl, "R6", "bare control word", bctl, exp_ctl);
        chk(bbus_req == 2'b00, "R6", "zero protection mask keeps request low", bbus_req, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctl == 32'h0000_0F12, "R1", "reset control word", ctl, 32'h0000_0F12);
        chk(bus_req == 2'b11, "R1", "reset protection request", bus_req, 2'b11);
        chk(!busy && !done && !err, "R1", "reset flags", {busy, done, err}, 0);
        chk(bctl == 32'h0000_0012, "R1", "bare reset control word", bctl, 32'h12);

        // sweep acknowledge delays
        for (int d = 0; d < 4; d++) begin
            d_pa = d; d_pb = d; d_sram = d; d_bus = d;
            run_seq(1'b1, 0); check_up();
            run_seq(1'b0, 0); check_down();
        end

        // R5 status lines disagree for several cycles
        d_pa = 0; d_pb = 6; d_sram = 0; d_bus = 0;
        run_seq(1'b1, 0); check_up();
        chk(s_pack >= s_p2 + 6, "R5", "waits through status mismatch", s_pack, s_p2 + 6);
        run_seq(1'b0, 0); check_down();
        d_pb = 0;

        // R8 request while busy is ignored
        run_seq(1'b1, 3); check_up();
        repeat (6) @(negedge clk);
        chk(!busy && ctl == 32'h0000_000D, "R8", "ignored request leaves domain on", ctl, 32'h0000_000D);
        run_seq(1'b0, 4); check_down();
        repeat (6) @(negedge clk);
        chk(!busy && ctl == 32'h0000_0F12, "R8", "ignored request leaves domain off", ctl, 32'h0000_0F12);

        // R7 power status stuck on power-up: revert to off
        st_pb = 1'b1;
        run_seq(1'b1, 0);
        chk(n_err == 1 && n_done == 0, "R7", "error without done on status timeout", n_err, 1);
        chk(ctl == 32'h0000_0F12, "R7", "reverted control word", ctl, 32'h0000_0F12);
        chk(bus_req == 2'b11, "R7", "protection held after revert", bus_req, 2'b11);
        chk(last_cyc < TMO + 20, "R7", "abort within timeout window", last_cyc, TMO + 20);
        st_pb = 1'b0;
        repeat (4) @(negedge clk);

        // R7 SRAM ack stuck on power-down: stop in place
        run_seq(1'b1, 0); check_up();
        st_sram = 1'b1;
        run_seq(1'b0, 0);
        chk(n_err == 1 && n_done == 0, "R7", "error on sram timeout in power-down", n_err, 1);
        chk(ctl == 32'h0000_0F0D, "R7", "power-down stops in place", ctl, 32'h0000_0F0D);
        st_sram = 1'b0;
        repeat (4) @(negedge clk);
        run_seq(1'b0, 0);
        chk(n_done == 1 && ctl == 32'h0000_0F12, "R7", "recovery power-down", ctl, 32'h0000_0F12);

        // R7 SRAM ack stuck on power-up: revert to off
        st_sram = 1'b1;
        run_seq(1'b1, 0);
        chk(n_err == 1 && n_done == 0, "R7", "error on sram timeout in power-up", n_err, 1);
        chk(ctl == 32'h0000_0F12, "R7", "reverted after sram timeout", ctl, 32'h0000_0F12);
        st_sram = 1'b0;
        repeat (4) @(negedge clk);

        // R7 protection ack stuck on power-up
        st_bus = 1'b1;
        run_seq(1'b1, 0);
        chk(n_err == 1 && ctl == 32'h0000_0F12, "R7", "reverted after protection timeout", ctl, 32'h0000_0F12);
        chk(bus_req == 2'b11, "R7", "protection reasserted", bus_req, 2'b11);
        st_bus = 1'b0;
        repeat (4) @(negedge clk);
        run_seq(1'b1, 0); check_up();
        run_seq(1'b0, 0); check_down();

        // R6 zero masks
        run_bare(1'b1, 32'h0000_000D);
        run_bare(1'b0, 32'h0000_0012);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule